// File: doc/BRIEF.md
# Component swizzle map generator

This unit prepares the byte-lane routing for a copy engine that reorders, drops or fills pixel components on the way from source to destination. It takes a packed format word, an element count per line and two 32-bit constant words. From these it builds a 16-byte map in which each byte names a source byte lane, a byte of one of the constants, or zero. It also derives the bytes per element on each side, the byte count of a source line and of a destination line, and a packed size word that carries both element sizes less one.

A job is accepted on `start_i` while the unit is idle. With format processing enabled, the unit walks every byte of every destination component, one map byte per cycle, and then spends one cycle settling the size results before it pulses `done_o`. With format processing disabled, it skips the walk and reports single-byte elements. All results are held until the next accepted job.

Top module: `swz_map_gen`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `map_o`, `const_o` and every size output are 0.
- R2: The component size is `fmt_i[17:16]`+1 bytes, the source component count is `fmt_i[21:20]`+1 and the destination component count is `fmt_i[25:24]`+1; `src_bpe_o` is size × source count and `dst_bpe_o` is size × destination count.
- R3: Destination component c takes its selector from `fmt_i[4c+3:4c]`; selector s in 0..3 gives map byte c×size+b the value s×size+b, for byte b of the component.
- R4: Selector 4 gives the value 0x10+b and selector 5 gives 0x14+b.
- R5: A selector of 6 or more gives the value 0x80.
- R6: Map bytes at or above destination count × size are 0 when the job finishes; map byte i is `map_o[8i+7:8i]`, so byte 0 is the low byte of word 0.
- R7: `dst_line_o` is `xcnt_i` × `dst_bpe_o` and `src_line_o` is `xcnt_i` × `src_bpe_o`.
- R8: When no used selector lies in 0..3, `src_line_o` is 0 while `src_bpe_o` keeps its value.
- R9: `size_pack_o[15:8]` is `dst_bpe_o`−1 and `size_pack_o[7:0]` is `src_bpe_o`−1.
- R10: With `fmt_en_i` low, both element sizes are 1, both line counts equal `xcnt_i`, `size_pack_o` is 0 and the map is all zero.
- R11: Counting the accepting edge as edge 0, `busy_o` is high after edges 0..N and `done_o` is a one-cycle pulse after edge N+1, where N is destination count × size with formatting and 0 without.
- R12: `start_i` while `busy_o` is high is ignored; the running job's results are unchanged.
- R13: `const_o` holds `{const1_i, const0_i}` as captured at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job when idle |
| fmt_en_i | input | 1 | Apply the format word; low selects plain byte copy |
| fmt_i | input | 32 | Selectors in bits 15:0, size and counts in bits 25:16 |
| xcnt_i | input | XCNT_W | Elements per line |
| const0_i | input | 32 | Constant word 0 |
| const1_i | input | 32 | Constant word 1 |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| map_o | output | 128 | Sixteen map bytes, byte i at bits 8i+7:8i |
| const_o | output | 64 | Captured constants, word 1 above word 0 |
| src_bpe_o | output | 5 | Source bytes per element |
| dst_bpe_o | output | 5 | Destination bytes per element |
| src_line_o | output | XCNT_W+5 | Source bytes per line |
| dst_line_o | output | XCNT_W+5 | Destination bytes per line |
| size_pack_o | output | 16 | Element sizes less one, destination above source |

## Verification
The completion pulse of one job and the acceptance of the next can share a cycle: the unit is already idle while `done_o` is high, so a `start_i` driven in that cycle must be taken at the following edge, clearing the map and restarting the count. The bench issues such back-to-back jobs with no idle gap and checks that the first job's results are read intact during the pulse and that the second job's busy and done timing matches its own length. It also drives `start_i` while a walk is under way and judges that the results still match the first job.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int MAP_BYTES = 16;
  localparam int BPE_W     = 5;
  localparam int SEL_W     = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GEN  = 2'd1,
    ST_FIN  = 2'd2
  } swz_state_e;
endpackage

// File: rtl/swz_cursor.sv
module swz_cursor (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic [1:0] cpp_m1_i,
  input  logic [1:0] nd_m1_i,
  output logic [1:0] comp_o,
  output logic [1:0] byte_o,
  output logic       last_o
);
  logic [1:0] comp_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      comp_q <= '0;
      byte_q <= '0;
    end else if (step_i) begin
      if (byte_q == cpp_m1_i) begin
        byte_q <= '0;
        comp_q <= comp_q + 2'd1;
      end else begin
        byte_q <= byte_q + 2'd1;
      end
    end
  end

  assign comp_o = comp_q;
  assign byte_o = byte_q;
  assign last_o = (comp_q == nd_m1_i) && (byte_q == cpp_m1_i);

  p_byte_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (byte_q <= cpp_m1_i) && (comp_q <= nd_m1_i));
endmodule

// File: rtl/swz_lane_enc.sv
module swz_lane_enc
  import swz_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       comp_i,
  input  logic [1:0]       byte_i,
  input  logic [1:0]       cpp_m1_i,
  output logic [3:0]       lane_o,
  output logic [7:0]       val_o,
  output logic             src_hit_o
);
  logic [3:0] cpp;

  always_comb begin
    cpp       = 4'(cpp_m1_i) + 4'd1;
    lane_o    = 4'(comp_i) * cpp + 4'(byte_i);
    src_hit_o = 1'b0;
    if (sel_i < 4'd4) begin
      val_o     = 8'(sel_i) * 8'(cpp) + 8'(byte_i);
      src_hit_o = 1'b1;
    end else if (sel_i == 4'd4) begin
      val_o = 8'h10 + 8'(byte_i);
    end else if (sel_i == 4'd5) begin
      val_o = 8'h14 + 8'(byte_i);
    end else begin
      val_o = 8'h80;
    end
  end
endmodule

// File: rtl/swz_size_calc.sv
module swz_size_calc
  import swz_pkg::*;
#(
  parameter  int XCNT_W = 16,
  localparam int LINE_W = XCNT_W + BPE_W
) (
  input  logic              fmt_en_i,
  input  logic [1:0]        cpp_m1_i,
  input  logic [1:0]        ns_m1_i,
  input  logic [1:0]        nd_m1_i,
  input  logic              src_ref_i,
  input  logic [XCNT_W-1:0] xcnt_i,
  output logic [BPE_W-1:0]  src_bpe_o,
  output logic [BPE_W-1:0]  dst_bpe_o,
  output logic [LINE_W-1:0] src_line_o,
  output logic [LINE_W-1:0] dst_line_o,
  output logic [15:0]       pack_o
);
  logic [BPE_W-1:0] cpp, ns, nd;

  always_comb begin
    cpp = BPE_W'(cpp_m1_i) + BPE_W'(1);
    ns  = BPE_W'(ns_m1_i) + BPE_W'(1);
    nd  = BPE_W'(nd_m1_i) + BPE_W'(1);
    if (fmt_en_i) begin
      src_bpe_o  = cpp * ns;
      dst_bpe_o  = cpp * nd;
      src_line_o = src_ref_i ? LINE_W'(xcnt_i) * LINE_W'(src_bpe_o) : '0;
      dst_line_o = LINE_W'(xcnt_i) * LINE_W'(dst_bpe_o);
    end else begin
      src_bpe_o  = BPE_W'(1);
      dst_bpe_o  = BPE_W'(1);
      src_line_o = LINE_W'(xcnt_i);
      dst_line_o = LINE_W'(xcnt_i);
    end
    pack_o = {8'(dst_bpe_o - BPE_W'(1)), 8'(src_bpe_o - BPE_W'(1))};
  end
endmodule

// File: rtl/swz_map_gen.sv
module swz_map_gen
  import swz_pkg::*;
#(
  parameter  int XCNT_W = 16,
  localparam int LINE_W = XCNT_W + BPE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   fmt_en_i,
  input  logic [31:0]            fmt_i,
  input  logic [XCNT_W-1:0]      xcnt_i,
  input  logic [31:0]            const0_i,
  input  logic [31:0]            const1_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [MAP_BYTES*8-1:0] map_o,
  output logic [63:0]            const_o,
  output logic [BPE_W-1:0]       src_bpe_o,
  output logic [BPE_W-1:0]       dst_bpe_o,
  output logic [LINE_W-1:0]      src_line_o,
  output logic [LINE_W-1:0]      dst_line_o,
  output logic [15:0]            size_pack_o
);
  swz_state_e state_q;
  logic [31:0]         fmt_q;
  logic                fmt_en_q;
  logic [XCNT_W-1:0]   xcnt_q;
  logic [63:0]         const_q;
  logic [MAP_BYTES-1:0][7:0] map_q;
  logic                src_ref_q, done_q;
  logic [BPE_W-1:0]    src_bpe_q, dst_bpe_q;
  logic [LINE_W-1:0]   src_line_q, dst_line_q;
  logic [15:0]         pack_q;

  logic start_acc;
  logic [1:0] cpp_m1, ns_m1, nd_m1, comp, bsel;
  logic last;
  logic [SEL_W-1:0] sel;
  logic [3:0] lane;
  logic [7:0] lane_val;
  logic src_hit;
  logic [BPE_W-1:0]  c_src_bpe, c_dst_bpe;
  logic [LINE_W-1:0] c_src_line, c_dst_line;
  logic [15:0]       c_pack;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign cpp_m1    = fmt_q[17:16];
  assign ns_m1     = fmt_q[21:20];
  assign nd_m1     = fmt_q[25:24];
  assign sel       = fmt_q[{comp, 2'b00} +: SEL_W];

  swz_cursor u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_acc),
    .step_i   (state_q == ST_GEN),
    .cpp_m1_i (cpp_m1),
    .nd_m1_i  (nd_m1),
    .comp_o   (comp),
    .byte_o   (bsel),
    .last_o   (last)
  );

  swz_lane_enc u_lane (
    .sel_i     (sel),
    .comp_i    (comp),
    .byte_i    (bsel),
    .cpp_m1_i  (cpp_m1),
    .lane_o    (lane),
    .val_o     (lane_val),
    .src_hit_o (src_hit)
  );

  swz_size_calc #(.XCNT_W(XCNT_W)) u_size (
    .fmt_en_i   (fmt_en_q),
    .cpp_m1_i   (cpp_m1),
    .ns_m1_i    (ns_m1),
    .nd_m1_i    (nd_m1),
    .src_ref_i  (src_ref_q),
    .xcnt_i     (xcnt_q),
    .src_bpe_o  (c_src_bpe),
    .dst_bpe_o  (c_dst_bpe),
    .src_line_o (c_src_line),
    .dst_line_o (c_dst_line),
    .pack_o     (c_pack)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fmt_q      <= '0;
      fmt_en_q   <= 1'b0;
      xcnt_q     <= '0;
      const_q    <= '0;
      map_q      <= '0;
      src_ref_q  <= 1'b0;
      done_q     <= 1'b0;
      src_bpe_q  <= '0;
      dst_bpe_q  <= '0;
      src_line_q <= '0;
      dst_line_q <= '0;
      pack_q     <= '0;
    end else if (start_acc) begin
      fmt_q     <= fmt_i;
      fmt_en_q  <= fmt_en_i;
      xcnt_q    <= xcnt_i;
      const_q   <= {const1_i, const0_i};
      map_q     <= '0;
      src_ref_q <= 1'b0;
      done_q    <= 1'b0;
      state_q   <= fmt_en_i ? ST_GEN : ST_FIN;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_GEN: begin
          map_q[lane] <= lane_val;
          src_ref_q   <= src_ref_q | src_hit;
          if (last) state_q <= ST_FIN;
        end
        ST_FIN: begin
          src_bpe_q  <= c_src_bpe;
          dst_bpe_q  <= c_dst_bpe;
          src_line_q <= c_src_line;
          dst_line_q <= c_dst_line;
          pack_q     <= c_pack;
          done_q     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign map_o       = map_q;
  assign const_o     = const_q;
  assign src_bpe_o   = src_bpe_q;
  assign dst_bpe_o   = dst_bpe_q;
  assign src_line_o  = src_line_q;
  assign dst_line_o  = dst_line_q;
  assign size_pack_o = pack_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_map_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (map_q == '0));
  p_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(fmt_q) && $stable(xcnt_q) && $stable(const_q));
  p_nofmt_lines_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fmt_en_q) |-> (src_line_o == dst_line_o) && (size_pack_o == 16'h0));
  p_pack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (size_pack_o[7:0] == 8'(src_bpe_o) - 8'd1)
            && (size_pack_o[15:8] == 8'(dst_bpe_o) - 8'd1));
endmodule

// File: tb/tb_swz_map_gen.sv
module tb_swz_map_gen;
  localparam int CLK_PERIOD = 10;
  localparam int XCNT_W = 16;
  localparam int LINE_W = XCNT_W + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic fmt_en = 1'b0;
  logic [31:0] fmt = '0;
  logic [XCNT_W-1:0] xcnt = '0;
  logic [31:0] c0 = '0, c1 = '0;
  logic busy, done;
  logic [127:0] map;
  logic [63:0] cst;
  logic [4:0] src_bpe, dst_bpe;
  logic [LINE_W-1:0] src_line, dst_line;
  logic [15:0] pack;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swz_map_gen #(.XCNT_W(XCNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt_en_i(fmt_en),
    .fmt_i(fmt), .xcnt_i(xcnt), .const0_i(c0), .const1_i(c1),
    .busy_o(busy), .done_o(done), .map_o(map), .const_o(cst),
    .src_bpe_o(src_bpe), .dst_bpe_o(dst_bpe), .src_line_o(src_line),
    .dst_line_o(dst_line), .size_pack_o(pack)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Job: driven at a negedge; returns at the negedge where done is sampled.
  task automatic run_job(input bit en, input logic [31:0] f, input int xc,
                         input logic [31:0] k0, input logic [31:0] k1,
                         input bit poke);
    int size, ns, nd, n, sbpe, dbpe, sline, dline;
    bit sref;
    int exp_map[16];
    string tag[16];
    size = f[17:16] + 1;
    ns   = f[21:20] + 1;
    nd   = f[25:24] + 1;
    sref = 1'b0;
    for (int i = 0; i < 16; i++) begin exp_map[i] = 0; tag[i] = "R6"; end
    if (en) begin
      for (int c = 0; c < nd; c++) begin
        for (int b = 0; b < size; b++) begin
          int s;
          s = (f >> (4*c)) & 15;
          if (s < 4) begin exp_map[c*size+b] = s*size + b; sref = 1'b1; tag[c*size+b] = "R3"; end
          else if (s == 4) begin exp_map[c*size+b] = 16 + b; tag[c*size+b] = "R4"; end
          else if (s == 5) begin exp_map[c*size+b] = 20 + b; tag[c*size+b] = "R4"; end
          else begin exp_map[c*size+b] = 128; tag[c*size+b] = "R5"; end
        end
      end
      n = nd * size; sbpe = size * ns; dbpe = size * nd;
      dline = xc * dbpe; sline = sref ? xc * sbpe : 0;
    end else begin
      n = 0; sbpe = 1; dbpe = 1; sline = xc; dline = xc;
      for (int i = 0; i < 16; i++) tag[i] = "R10";
    end
    start = 1'b1; fmt_en = en; fmt = f; xcnt = XCNT_W'(xc); c0 = k0; c1 = k1;
    for (int k = 0; k <= n + 1; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) begin start = 1'b0; fmt = 32'h0F0F_FFFF; xcnt = '1; c0 = '1; c1 = '1; end
      if (poke && k == 1) start = 1'b1;       // R12: start while busy
      if (poke && k == 2) start = 1'b0;
      chk("R11 busy", busy, (k <= n));
      chk("R11 done", done, (k == n + 1));
    end
    for (int i = 0; i < 16; i++) chk(tag[i], map[8*i +: 8], exp_map[i]);
    chk(en ? "R2 src_bpe" : "R10 src_bpe", src_bpe, sbpe);
    chk(en ? "R2 dst_bpe" : "R10 dst_bpe", dst_bpe, dbpe);
    chk(en ? "R7 dst_line" : "R10 dst_line", dst_line, dline);
    chk((en && !sref) ? "R8 src_line" : "R7 src_line", src_line, sline);
    chk("R9 pack", pack, en ? (((dbpe-1) << 8) | (sbpe-1)) : 0);
    chk("R13 const", cst, {k1, k0});
    if (poke) chk("R12 start ignored", map[7:0], exp_map[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 map", map[63:0], 0);
    chk("R1 map hi", map[127:64], 0);
    chk("R1 const", cst, 0);
    chk("R1 sizes", {src_bpe, dst_bpe, pack}, 0);
    chk("R1 lines", {src_line, dst_line}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busy, 0);

    // component reversal, byte elements
    run_job(1'b1, 32'h0330_0123, 100, 32'h1111_2222, 32'h3333_4444, 1'b0);
    @(negedge clk);
    // one 4-byte component
    run_job(1'b1, 32'h0003_0000, 7, 32'hA5A5_0001, 32'h0, 1'b0);
    @(negedge clk);
    // constants and zero only: no source reference
    run_job(1'b1, 32'h0211_0754, 33, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0);
    @(negedge clk);
    // no format, largest count
    run_job(1'b0, 32'h0333_3210, 16'hFFFF, 32'h5, 32'h6, 1'b0);
    @(negedge clk);
    // full 16-byte map, large selectors, start while busy
    run_job(1'b1, 32'h0333_20F1, 16'hFFFF, 32'h1, 32'h2, 1'b1);
    // back to back: next job starts in the done cycle
    run_job(1'b1, 32'h0311_5410, 9, 32'h7, 32'h8, 1'b0);
    run_job(1'b0, 32'h0, 0, 32'h9, 32'hA, 1'b0);
    run_job(1'b1, 32'h0121_0006, 3, 32'hB, 32'hC, 1'b1);
    @(negedge clk);
    chk("R11 done cleared", done, 0);
    finish_run();
  end
endmodule